// File: doc/BRIEF.md
# Periodic Boundary Row Reorder Buffer

This block sits at the output of a stencil update pipeline that produces one grid row of cells per pass, one cell per clock, in ascending index order. The two end cells of each row follow a periodic rule: the lowest cell takes a copy of the core cell at index NX-2, and the highest cell takes a copy of the core cell at index 1. Because the source for the lowest cell arrives near the end of the row, the lowest cell can only be formed after most of the row has passed. The block still emits the row strictly in ascending order.

Each incoming cell enters a shift line of NX-1 stages. The copy for the highest cell is taken one cycle after cell 1 enters the line. It is held in a side register and is written into the line in place of whatever value arrives in the highest input slot. The copy for the lowest cell is taken one cycle after cell NX-2 enters. At that moment cell 0 sits in the last stage, so the output register loads the value of cell NX-2 in its place. Every cell therefore leaves exactly NX-1 clock cycles after it was sampled. Rows may follow one another with no idle cycles, or with gaps between them.

The input carries no row marker. Cell positions are counted from reset, so each row must arrive as NX contiguous valid cycles.

Top module: `pbc_row_reorder`

## Requirements
- R1: While reset is high and on the first cycle after it is released, out_valid is 0.
- R2: For every core index i with 1 <= i <= NX-2, the output cell at index i carries the value that entered at index i of the same row.
- R3: The output cell at index 0 carries the value that entered at index NX-2 of the same row; the value presented at input index 0 never reaches the output.
- R4: The output cell at index NX-1 carries the value that entered at index 1 of the same row; the value presented at input index NX-1 never reaches the output.
- R5: Each row leaves in ascending index order 0 to NX-1 on consecutive cycles. out_first is 1 only with index 0, and out_last is 1 only with index NX-1.
- R6: A cell sampled at a rising edge with in_valid high is visible on the outputs after exactly NX-1 further rising edges.
- R7: Rows presented back to back with no idle cycles leave back to back at one cell per cycle. Idle cycles between rows are preserved at the output.
- R8: The first valid cycle after reset is index 0. Once a row has started, in_valid stays high for all NX cycles of that row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input cell valid |
| in_data | input | DATA_W | Input cell value, ascending index order |
| out_valid | output | 1 | Output cell valid |
| out_data | output | DATA_W | Output cell value, ascending index order |
| out_first | output | 1 | Output cell is index 0 of its row |
| out_last | output | 1 | Output cell is index NX-1 of its row |

## Verification
Two actions can fall in the same clock edge. One is forming the low boundary of a row at the output register. The other is capturing the next row's cell 1 into the side register, or writing the stored high boundary into the line. Back-to-back rows force these actions to overlap, and so do rows separated by a single idle cycle. In each case the bench checks that every emitted cell equals the value predicted from that cell's own row. It also checks that each cell appears on exactly the cycle given by the fixed latency. The ignored end slots carry distinctive junk, so any leak of those values or any copy taken from the wrong row shows up as a data mismatch.

// File: rtl/pbc_reorder_pkg.sv
package pbc_reorder_pkg;
  // Bits needed to count positions 0 .. n-1 (at least one bit).
  function automatic int unsigned pos_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pbc_row_index.sv
module pbc_row_index #(
  parameter int unsigned NX    = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(NX - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst)
      idx_q <= '0;
    else if (adv)
      idx_q <= (idx_q == TOP) ? '0 : idx_q + IDX_W'(1);
  end

  assign idx = idx_q;

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx_q <= TOP); // R5
endmodule

// File: rtl/pbc_shift_line.sv
module pbc_shift_line #(
  parameter int unsigned DEPTH = 7,
  parameter int unsigned W     = 35
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_vld,
  input  logic [W-1:0]              in_word,
  output logic [DEPTH-1:0]          tap_vld,
  output logic [DEPTH-1:0][W-1:0]   tap_word
);
  logic [DEPTH-1:0]        vld_q;
  logic [DEPTH-1:0][W-1:0] word_q;

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) vld_q[s] <= 1'b0;
          else     vld_q[s] <= in_vld;
          word_q[s] <= in_word;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) vld_q[s] <= 1'b0;
          else     vld_q[s] <= vld_q[s-1];
          word_q[s] <= word_q[s-1];
        end
        AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
          vld_q[s-1] |=> vld_q[s]); // R6
      end
    end
  endgenerate

  assign tap_vld  = vld_q;
  assign tap_word = word_q;
endmodule

// File: rtl/pbc_row_reorder.sv
module pbc_row_reorder #(
  parameter int unsigned NX     = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_first,
  output logic              out_last
);
  localparam int unsigned IDX_W = pbc_reorder_pkg::pos_bits(NX);
  localparam int unsigned DEPTH = NX - 1;
  localparam int unsigned W     = IDX_W + DATA_W;
  localparam logic [IDX_W-1:0] POS_LO   = '0;
  localparam logic [IDX_W-1:0] POS_ONE  = IDX_W'(1);
  localparam logic [IDX_W-1:0] POS_SRC  = IDX_W'(NX - 2);
  localparam logic [IDX_W-1:0] POS_HI   = IDX_W'(NX - 1);

  typedef struct packed {
    logic [IDX_W-1:0]  pos;
    logic [DATA_W-1:0] val;
  } cell_t;

  logic [IDX_W-1:0]         in_pos;
  logic [DATA_W-1:0]        wrap_q;
  cell_t                    line_in;
  logic [DEPTH-1:0]         tap_vld;
  logic [DEPTH-1:0][W-1:0]  tap_word;
  cell_t                    head, tail;
  logic                     head_vld, tail_vld;

  logic              out_valid_q, out_first_q, out_last_q;
  logic [DATA_W-1:0] out_data_q;

  pbc_row_index #(.NX(NX), .IDX_W(IDX_W)) u_index (
    .clk (clk),
    .rst (rst),
    .adv (in_valid),
    .idx (in_pos)
  );

  // The high boundary slot is overwritten with the saved copy of cell 1.
  always_comb begin
    line_in.pos = in_pos;
    line_in.val = (in_pos == POS_HI) ? wrap_q : in_data;
  end

  pbc_shift_line #(.DEPTH(DEPTH), .W(W)) u_line (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_valid),
    .in_word  (line_in),
    .tap_vld  (tap_vld),
    .tap_word (tap_word)
  );

  assign head     = cell_t'(tap_word[0]);
  assign tail     = cell_t'(tap_word[DEPTH-1]);
  assign head_vld = tap_vld[0];
  assign tail_vld = tap_vld[DEPTH-1];

  // Copy of cell 1, taken one cycle after it enters the line.
  always_ff @(posedge clk) begin
    if (head_vld && head.pos == POS_ONE)
      wrap_q <= head.val;
  end

  // Low boundary: when cell 0 reaches the tail, cell NX-2 is at the head.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_first_q <= 1'b0;
      out_last_q  <= 1'b0;
    end else begin
      out_valid_q <= tail_vld;
      out_first_q <= tail_vld && (tail.pos == POS_LO);
      out_last_q  <= tail_vld && (tail.pos == POS_HI);
    end
    out_data_q <= (tail.pos == POS_LO) ? head.val : tail.val;
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign out_first = out_first_q;
  assign out_last  = out_last_q;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !out_valid); // R1
  AST_ROW_CONTIG: assert property (@(posedge clk) disable iff (rst)
    (in_pos != POS_LO) |-> in_valid); // R8
  AST_LOW_SRC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (tail_vld && tail.pos == POS_LO) |-> (head_vld && head.pos == POS_SRC)); // R3
  AST_HIGH_SRC_SAVED: assert property (@(posedge clk) disable iff (rst)
    (head_vld && head.pos == POS_HI) |-> tap_vld[NX-3]); // R4
  AST_TAIL_TO_OUT: assert property (@(posedge clk) disable iff (rst)
    tail_vld |=> out_valid); // R6
  AST_ROW_UNBROKEN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> (out_valid && !out_first)); // R5
  AST_NEXT_ROW_START: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |=> (!out_valid || out_first)); // R7
endmodule

// File: tb/pbc_row_reorder_tb_top.sv
module pbc_row_reorder_tb_top;
  localparam int NX     = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid, out_first, out_last;
  logic [DATA_W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  string lat_tag = "R6";

  logic [DATA_W-1:0] q_val[$];
  int                q_cyc[$];
  int                q_pos[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pbc_row_reorder #(.NX(NX), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .out_first(out_first), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // Output monitor against the queue of predicted cells.
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (q_val.size() == 0) begin
          check(0, "R7", "unexpected output", 1, 0);
        end else begin
          automatic logic [DATA_W-1:0] ev = q_val.pop_front();
          automatic int ec = q_cyc.pop_front();
          automatic int ep = q_pos.pop_front();
          automatic string dtag = (ep == 0) ? "R3" : (ep == NX-1) ? "R4" : "R2";
          check(out_data == ev, dtag, $sformatf("data at index %0d", ep), out_data, ev);
          check(cyc == ec, lat_tag, "output cycle", cyc, ec);
          check(out_first == (ep == 0) && out_last == (ep == NX-1), "R5",
                "first/last flags", {out_first, out_last},
                {1'(ep == 0), 1'(ep == NX-1)});
        end
      end else if (q_cyc.size() != 0 && q_cyc[0] <= cyc) begin
        check(0, lat_tag, "missing output", 0, 1);
        void'(q_val.pop_front()); void'(q_cyc.pop_front()); void'(q_pos.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = $urandom;
    end
  endtask

  // Drives one row; slots 0 and NX-1 carry junk that must be ignored.
  task automatic send_row(input logic [DATA_W-1:0] core [NX]);
    for (int i = 0; i < NX; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = core[i];
      q_val.push_back((i == 0) ? core[NX-2] : (i == NX-1) ? core[1] : core[i]);
      q_cyc.push_back(cyc + NX);
      q_pos.push_back(i);
    end
  endtask

  task automatic rand_row(output logic [DATA_W-1:0] r [NX]);
    for (int i = 0; i < NX; i++) r[i] = $urandom;
    r[0]    = 32'hDEAD_0000 | 32'(i_junk());
    r[NX-1] = 32'hBEEF_0000 | 32'(i_junk());
  endtask

  function automatic int i_junk();
    return int'($urandom_range(0, 16'hFFFF));
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
  endtask

  task automatic t_single_row();
    logic [DATA_W-1:0] r [NX];
    lat_tag = "R6";
    rand_row(r);
    send_row(r);
    idle(NX + 3);
  endtask

  task automatic t_back_to_back();
    logic [DATA_W-1:0] r [NX];
    lat_tag = "R7";
    for (int n = 0; n < 6; n++) begin
      rand_row(r);
      send_row(r);
    end
    idle(NX + 3);
  endtask

  task automatic t_gapped();
    logic [DATA_W-1:0] r [NX];
    lat_tag = "R7";
    for (int n = 0; n < 8; n++) begin
      rand_row(r);
      send_row(r);
      idle((n % 3) + 1);
    end
    idle(NX + 3);
  endtask

  task automatic t_extremes();
    logic [DATA_W-1:0] r [NX];
    lat_tag = "R6";
    for (int i = 0; i < NX; i++) r[i] = '1;
    r[0] = '0; r[NX-1] = '0;
    send_row(r);
    for (int i = 0; i < NX; i++) r[i] = '0;
    r[0] = '1; r[NX-1] = '1;
    send_row(r);
    for (int i = 0; i < NX; i++) r[i] = DATA_W'(i + 1);
    r[0] = 32'h5A5A_5A5A; r[NX-1] = 32'hA5A5_A5A5;
    send_row(r);
    idle(NX + 3);
  endtask

  task automatic t_drain();
    idle(2 * NX);
    check(q_val.size() == 0, "R7", "cells left undelivered", q_val.size(), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_single_row();
    t_back_to_back();
    t_gapped();
    t_extremes();
    t_drain();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule